// File: doc/BRIEF.md
# Serial Nested-Parity Checksum Codec

The block protects one data byte with a checksum byte of nested parities. Checksum bit k is the even parity of data bits k down to 0. Bit 7 therefore covers the whole byte, and bit 0 is a copy of the data LSB. The codeword is twice the data width. The data sits in the upper half with its MSB leftmost, and the checksum fills the lower half.

The encoder is a serial shift register. It clears itself when it accepts a start, then shifts the byte in LSB first for two full passes. During the second pass, one register stage feeds back onto itself. As the first copy of the byte moves down into the lower half, this stage builds the running parity. A one-cycle done pulse marks a finished codeword.

The decoder takes a received codeword, which it assumes has an error-free checksum. It compares the checksum against one recomputed from the received data. If they differ, it checks each of the single-data-bit-flip hypotheses and applies the one whose checksum matches the received checksum. A mismatch that no single flip explains raises an uncorrectable flag, and the data passes through unchanged. The decision logic is combinational, and its result is registered once.

Top module: `pcc_codec`

## Requirements
- R1: When the encoder signals done, the upper half of `enc_word` equals the byte latched when the start was accepted.
- R2: When the encoder signals done, bit k of the lower half of `enc_word` (bit 0 least significant) equals the XOR of data bits k..0. Data 0xAB gives the codeword 0xAB99.
- R3: `enc_done` is high for exactly one cycle, and the first sampling point where it is high falls 16 clock edges after the edge that accepted the start. `enc_busy` is high while the shifts run.
- R4: A start that arrives while the encoder is busy is ignored. It changes neither the codeword nor the done timing.
- R5: `dec_out_valid` rises on the clock edge after `dec_valid` is sampled high and lasts one cycle per accepted word.
- R6: A received word whose checksum equals the recomputed one returns its data unchanged, with `dec_fixed` and `dec_bad` low.
- R7: Any mismatch (syndrome) equal to the ones in checksum bits 7..i with zeros below is corrected by flipping data bit i, and `dec_fixed` rises. Received 0xAA99 gives data 0xAB.
- R8: Any nonzero syndrome of another shape sets `dec_bad`, clears `dec_fixed` and passes the received data through. Received 0x2A99 gives data 0x2A with `dec_bad` set.
- R9: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_start | input | 1 | Request to encode `enc_data` (taken only when idle) |
| enc_data | input | DATA_W | Byte to encode |
| enc_busy | output | 1 | Encoder is shifting |
| enc_done | output | 1 | One-cycle pulse: `enc_word` is complete |
| enc_word | output | 2*DATA_W | Codeword: data in upper half, checksum in lower half |
| dec_valid | input | 1 | `dec_word` carries a received codeword |
| dec_word | input | 2*DATA_W | Received codeword |
| dec_out_valid | output | 1 | Decoded result valid this cycle |
| dec_data | output | DATA_W | Decoded (possibly corrected) data |
| dec_fixed | output | 1 | A single data-bit error was corrected |
| dec_bad | output | 1 | Syndrome matches no single-bit hypothesis |

## Verification
The bench builds the codec with the default DATA_W of 8, which keeps the data space small enough to enumerate. At that width, every byte value goes through the serial encoder, including the cycle position of the done pulse. Every byte is decoded clean and with each of its eight single flips. Seeded random corruption masks and checksum-only flips then reach the uncorrectable path from many different syndromes.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef enum logic [1:0] {
        DEC_CLEAN = 2'd0,
        DEC_FIXED = 2'd1,
        DEC_BAD   = 2'd2
    } dec_status_e;

    // Nested parity: bit k = XOR of d[k:0]; bits at or above w are zero.
    function automatic logic [31:0] chain_parity(input logic [31:0] d, input int w);
        logic [31:0] r;
        logic        acc;
        acc = 1'b0;
        r   = '0;
        for (int k = 0; k < 32; k++) begin
            acc  = acc ^ d[k];
            r[k] = (k < w) ? acc : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/pcc_encoder.sv
module pcc_encoder #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DATA_W-1:0]     data,
    output logic                  busy,
    output logic                  done,
    output logic [2*DATA_W-1:0]   word
);
    import pcc_pkg::*;

    localparam int WORD_W = 2 * DATA_W;
    localparam int CW     = $clog2(WORD_W);
    localparam int IW     = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
    localparam logic [CW-1:0] HALF = CW'(DATA_W);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] src;
        logic [WORD_W-1:0] sr;
    } enc_state_t;

    enc_state_t s_d, s_q;
    logic [CW-1:0] pos;
    logic          in_bit;

    always_comb begin
        pos    = (s_q.cnt >= HALF) ? (s_q.cnt - HALF) : s_q.cnt;
        in_bit = s_q.src[IW'(pos)];
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.src  = data;
                s_d.sr   = '0;
            end
        end else begin
            s_d.sr           = {in_bit, s_q.sr[WORD_W-1:1]};
            // self-feedback stage accumulates the running parity
            s_d.sr[DATA_W-1] = s_q.sr[DATA_W] ^ s_q.sr[DATA_W-1];
            if (s_q.cnt == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign word = s_q.sr;

    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> $past(s_q.busy));
    p_upper_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> s_q.sr[WORD_W-1:DATA_W] == s_q.src);
    p_lower_chain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> s_q.sr[DATA_W-1:0] ==
            DATA_W'(chain_parity(32'(s_q.sr[WORD_W-1:DATA_W]), DATA_W)));
    p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != LAST) |=> $stable(s_q.src) && s_q.busy);

endmodule

// File: rtl/pcc_hyp_decoder.sv
module pcc_hyp_decoder #(
    parameter int DATA_W = 8
) (
    input  logic [2*DATA_W-1:0]   rx_word,
    output logic [DATA_W-1:0]     fix_data,
    output pcc_pkg::dec_status_e  status
);
    import pcc_pkg::*;

    logic [DATA_W-1:0] rx_d, rx_cs, own_cs, match;

    assign rx_d   = rx_word[2*DATA_W-1:DATA_W];
    assign rx_cs  = rx_word[DATA_W-1:0];
    assign own_cs = DATA_W'(chain_parity(32'(rx_d), DATA_W));

    for (genvar i = 0; i < DATA_W; i++) begin : g_hyp
        logic [DATA_W-1:0] trial;
        assign trial    = rx_d ^ (DATA_W'(1) << i);
        assign match[i] = (DATA_W'(chain_parity(32'(trial), DATA_W)) == rx_cs);
    end

    always_comb begin
        fix_data = rx_d;
        status   = DEC_CLEAN;
        if (own_cs != rx_cs) begin
            if (|match) begin
                fix_data = rx_d ^ match;
                status   = DEC_FIXED;
            end else begin
                status   = DEC_BAD;
            end
        end
    end

endmodule

// File: rtl/pcc_codec.sv
module pcc_codec #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enc_start,
    input  logic [DATA_W-1:0]     enc_data,
    output logic                  enc_busy,
    output logic                  enc_done,
    output logic [2*DATA_W-1:0]   enc_word,
    input  logic                  dec_valid,
    input  logic [2*DATA_W-1:0]   dec_word,
    output logic                  dec_out_valid,
    output logic [DATA_W-1:0]     dec_data,
    output logic                  dec_fixed,
    output logic                  dec_bad
);
    import pcc_pkg::*;

    localparam int WORD_W = 2 * DATA_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic              fixed;
        logic              bad;
    } dec_out_t;

    dec_out_t    o_d, o_q;
    logic [DATA_W-1:0] fix_data;
    dec_status_e       status;

    pcc_encoder #(.DATA_W(DATA_W)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (enc_start),
        .data  (enc_data),
        .busy  (enc_busy),
        .done  (enc_done),
        .word  (enc_word)
    );

    pcc_hyp_decoder #(.DATA_W(DATA_W)) u_dec (
        .rx_word  (dec_word),
        .fix_data (fix_data),
        .status   (status)
    );

    always_comb begin
        o_d     = o_q;
        o_d.vld = dec_valid;
        if (dec_valid) begin
            o_d.data  = fix_data;
            o_d.fixed = (status == DEC_FIXED);
            o_d.bad   = (status == DEC_BAD);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dec_out_valid = o_q.vld;
    assign dec_data      = o_q.data;
    assign dec_fixed     = o_q.fixed;
    assign dec_bad       = o_q.bad;

    p_out_follows_in_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid |-> $past(dec_valid));
    p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid |-> !(dec_fixed && dec_bad));
    p_good_matches_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && !dec_bad) |->
            DATA_W'(chain_parity(32'(dec_data), DATA_W)) == $past(dec_word[DATA_W-1:0]));
    p_bad_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && dec_bad) |-> dec_data == $past(dec_word[WORD_W-1:DATA_W]));

endmodule

// File: tb/test_pcc_codec.sv
module test_pcc_codec;

    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enc_start = 1'b0;
    logic [W-1:0]   enc_data = '0;
    logic           enc_busy, enc_done;
    logic [2*W-1:0] enc_word;
    logic           dec_valid = 1'b0;
    logic [2*W-1:0] dec_word = '0;
    logic           dec_out_valid, dec_fixed, dec_bad;
    logic [W-1:0]   dec_data;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pcc_codec #(.DATA_W(W)) i_pcc_codec (
        .clk(clk), .rst_n(rst_n),
        .enc_start(enc_start), .enc_data(enc_data),
        .enc_busy(enc_busy), .enc_done(enc_done), .enc_word(enc_word),
        .dec_valid(dec_valid), .dec_word(dec_word),
        .dec_out_valid(dec_out_valid), .dec_data(dec_data),
        .dec_fixed(dec_fixed), .dec_bad(dec_bad)
    );

    function automatic logic [W-1:0] ref_cs(input logic [W-1:0] d);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) begin
            r[k] = 1'b0;
            for (int j = 0; j <= k; j++) r[k] = r[k] ^ d[j];
        end
        return r;
    endfunction

    // expected decode: {bad, fixed, data}
    function automatic logic [W+1:0] ref_dec(input logic [2*W-1:0] w);
        logic [W-1:0] d, syn, run;
        int n;
        d   = w[2*W-1:W];
        syn = w[W-1:0] ^ ref_cs(d);
        if (syn == '0) return {2'b00, d};
        n = $countones(syn);
        run = '0;
        for (int k = 0; k < n; k++) run[W-1-k] = 1'b1;
        if (syn == run) begin
            d[W-n] = ~d[W-n];
            return {2'b01, d};
        end
        return {2'b10, d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic enc_run(input logic [W-1:0] d, input bit interfere);
        int first_k;
        logic [2*W-1:0] got;
        first_k = -1;
        got = '0;
        @(negedge clk);
        enc_start = 1'b1;
        enc_data  = d;
        @(negedge clk);
        enc_start = 1'b0;
        for (int k = 1; k <= 18; k++) begin
            @(negedge clk);
            if (k == 5 && interfere) begin
                enc_start = 1'b1;
                enc_data  = ~d;
            end
            if (k == 6) enc_start = 1'b0;
            if (k == 1) chk(enc_busy == 1'b1, "R3 busy", 32'(enc_busy), 1);
            if (enc_done && first_k < 0) begin
                first_k = k;
                got = enc_word;
            end
            if (k == 17) chk(enc_done == 1'b0, "R3 pulse", 32'(enc_done), 0);
        end
        chk(first_k == 16, interfere ? "R4 timing" : "R3 timing", 32'(first_k), 16);
        chk(got[2*W-1:W] == d, interfere ? "R4 data" : "R1", 32'(got[2*W-1:W]), 32'(d));
        chk(got[W-1:0] == ref_cs(d), "R2", 32'(got[W-1:0]), 32'(ref_cs(d)));
    endtask

    task automatic dec_run(input logic [2*W-1:0] w);
        logic [W+1:0] e;
        e = ref_dec(w);
        @(negedge clk);
        dec_valid = 1'b1;
        dec_word  = w;
        @(negedge clk);
        dec_valid = 1'b0;
        chk(dec_out_valid == 1'b1, "R5", 32'(dec_out_valid), 1);
        chk(dec_data == e[W-1:0],
            e[W+1] ? "R8 data" : (e[W] ? "R7 data" : "R6 data"), 32'(dec_data), 32'(e[W-1:0]));
        chk({dec_bad, dec_fixed} == e[W+1:W],
            e[W+1] ? "R8 flags" : (e[W] ? "R7 flags" : "R6 flags"),
            32'({dec_bad, dec_fixed}), 32'(e[W+1:W]));
        @(negedge clk);
        chk(dec_out_valid == 1'b0, "R5 pulse", 32'(dec_out_valid), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk({enc_busy, enc_done, enc_word, dec_out_valid, dec_data, dec_fixed, dec_bad} == '0,
            "R9", 32'(enc_word), 0);

        // directed corners
        enc_run(8'hAB, 1'b0);                 // R2 example 0xAB -> 0x99
        chk(enc_word == 16'hAB99, "R2 example", 32'(enc_word), 32'hAB99);
        enc_run(8'h3C, 1'b1);                 // R4 start while busy
        dec_run(16'hAB99);                    // R6 clean
        dec_run(16'hAA99);                    // R7 LSB flip
        chk(dec_data == 8'hAB, "R7 example", 32'(dec_data), 32'hAB);
        dec_run(16'h2A99);                    // R8 double error
        chk(dec_bad == 1'b1 && dec_data == 8'h2A, "R8 example", 32'({dec_bad, dec_data}), 32'h12A);
        dec_run({8'h55, ref_cs(8'h55) ^ 8'h01}); // R8 checksum-only flip

        // exhaustive encode and single-flip decode
        for (int v = 0; v < 256; v++) begin
            enc_run(8'(v), 1'b0);
            dec_run({8'(v), ref_cs(8'(v))});
            for (int b = 0; b < W; b++) dec_run({8'(v) ^ (8'd1 << b), ref_cs(8'(v))});
        end

        // seeded random corruption
        for (int t = 0; t < 600; t++) begin
            logic [W-1:0] d;
            logic [2*W-1:0] m;
            d = 8'($urandom);
            m = 16'($urandom);
            dec_run({d, ref_cs(d)} ^ m);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule